// File: doc/BRIEF.md
# Asynchronous HDLC Receive Deframer

This block sits behind a UART-style character receiver and rebuilds HDLC frames that were sent with asynchronous octet stuffing. It accepts one received character per accepted handshake. Flag characters mark frame boundaries, and a single flag may end one frame and start the next. An escape character is removed and the character after it is restored. Control characters selected by a 32-bit map are dropped as line noise. The block checks the 16-bit frame check sequence at each closing flag.

Unescaped frame bytes leave on a valid/ready stream with a last marker. The two check bytes are never forwarded. The final beat of each frame carries a three-bit status with these bits: bit 0 CRC error, bit 1 aborted, bit 2 too short. The flag value, the escape value and the control map are configuration inputs. They are meant to be changed only while the line is idle between frames. When the output is stalled, the input ready falls, so the receiver has to wait.

Top module: `hdlc_async_deframer`

## Requirements
- R1: After reset, every character before the first flag is discarded and produces no output. The first flag opens a frame.
- R2: A flag that closes a non-empty frame also opens the next frame, so back-to-back frames separated by one flag are both delivered.
- R3: The escape character is removed, and the character after it is delivered XOR 0x20. That following character is never treated as flag, escape or map-filtered, unless it equals the flag.
- R4: A received character c below 0x20 with cfg_ctrl_map[c]=1 is dropped when it does not follow an escape. Dropping it has no effect on data or CRC.
- R5: The flag and escape values come from cfg_flag and cfg_esc. With other values programmed, 0x7E and 0x7D pass as plain data.
- R6: The CRC is the reflected CCITT 16-bit CRC, with polynomial 0x8408 and initial value 0xFFFF, computed over all unescaped bytes including the two check bytes. A frame of four or more bytes whose residue is not 0xF0B8 ends with status 3'b001.
- R7: For a frame of m ≥ 4 unescaped bytes, the first m-2 bytes are delivered in order. Byte m-2 carries out_last=1 and the CRC status. Non-last beats carry status 0.
- R8: An escape followed directly by a flag aborts the frame. One last beat with status 3'b010 is delivered, whose data is byte m-2 when m ≥ 3 and otherwise 0x00. Bytes 1 to m-3 are delivered before it. That flag opens the next frame.
- R9: A frame of 1 to 3 bytes gives one beat with out_last=1 and status 3'b100. Its data is the first byte when m=3 and otherwise 0x00. Two adjacent flags produce no output.
- R10: in_ready equals !out_valid || out_ready. While out_valid=1 and out_ready=0, the output beat is held unchanged.
- R11: During and right after reset, out_valid is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_flag | input | 8 | Flag character value |
| cfg_esc | input | 8 | Escape character value |
| cfg_ctrl_map | input | 32 | Drop mask for characters 0x00 to 0x1F |
| in_valid | input | 1 | Received character valid |
| in_data | input | 8 | Received character |
| in_ready | output | 1 | Character accepted when high with in_valid |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts beat |
| out_data | output | 8 | Unescaped frame byte |
| out_last | output | 1 | Final beat of a frame |
| out_status | output | 3 | Frame status on the last beat: {too_short, aborted, crc_error} |

## Verification
The assertions rely on three things. The configuration inputs stay constant while characters are in flight. The downstream side drops out_ready only as a handshake choice and never depends on in_valid. The programmed flag differs from the escape value. The stimulus follows these limits in the following ways:
- It changes the flag, escape and map values only after the output has drained.
- It always picks distinct flag and escape values.
- It drives out_ready from its own random process with no link to the sender.
- It escapes data only where the escaped form cannot equal the flag.

// File: rtl/hdlcd_pkg.sv
package hdlcd_pkg;

    localparam int BYTE_W      = 8;
    localparam int CTRL_SPAN   = 32;
    localparam int CTRL_IDX_W  = $clog2(CTRL_SPAN);
    localparam int FCS_LEN     = 2;
    localparam logic [15:0] CRC_INIT = 16'hFFFF;
    localparam logic [15:0] CRC_GOOD = 16'hF0B8;
    localparam logic [15:0] CRC_POLY = 16'h8408;
    localparam logic [BYTE_W-1:0] ESC_XOR = 8'h20;

    typedef enum logic [1:0] {
        CK_DROP  = 2'd0,
        CK_DATA  = 2'd1,
        CK_FLAG  = 2'd2,
        CK_ABORT = 2'd3
    } chr_kind_t;

    typedef struct packed {
        logic too_short;
        logic aborted;
        logic crc_bad;
    } frm_stat_t;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              last;
        frm_stat_t         stat;
    } beat_t;

    function automatic logic [15:0] crc16_byte(input logic [15:0] crc_in,
                                               input logic [BYTE_W-1:0] b);
        logic [15:0] c;
        c = crc_in ^ {8'h00, b};
        for (int k = 0; k < BYTE_W; k++) begin
            c = c[0] ? ((c >> 1) ^ CRC_POLY) : (c >> 1);
        end
        return c;
    endfunction

endpackage

// File: rtl/hdlcd_classify.sv
module hdlcd_classify
    import hdlcd_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [BYTE_W-1:0]     cfg_flag,
    input  logic [BYTE_W-1:0]     cfg_esc,
    input  logic [CTRL_SPAN-1:0]  cfg_map,
    input  logic                  take,
    input  logic [BYTE_W-1:0]     ch,
    output chr_kind_t             kind,
    output logic [BYTE_W-1:0]     byte_o
);

    logic esc_q;
    logic ctrl_sel;

    assign ctrl_sel = (ch[BYTE_W-1:CTRL_IDX_W] == '0) && cfg_map[ch[CTRL_IDX_W-1:0]];

    always_comb begin
        byte_o = ch;
        if (ch == cfg_flag) begin
            kind = esc_q ? CK_ABORT : CK_FLAG;
        end else if (esc_q) begin
            kind   = CK_DATA;
            byte_o = ch ^ ESC_XOR;
        end else if (ch == cfg_esc) begin
            kind = CK_DROP;
        end else if (ctrl_sel) begin
            kind = CK_DROP;
        end else begin
            kind = CK_DATA;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            esc_q <= 1'b0;
        end else if (take) begin
            esc_q <= (ch != cfg_flag) && !esc_q && (ch == cfg_esc);
        end
    end

    // R8
    esc_clear_chk: assert property (@(posedge clk) disable iff (rst)
        take && (ch == cfg_flag) |=> !esc_q);

endmodule

// File: rtl/hdlcd_frame.sv
module hdlcd_frame
    import hdlcd_pkg::*;
#(
    parameter int MIN_LEN = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  chr_kind_t         kind,
    input  logic [BYTE_W-1:0] byte_i,
    output logic              emit,
    output beat_t             beat
);

    localparam int CNT_W   = $clog2(MIN_LEN + 1);
    localparam int HOLD_AT = FCS_LEN + 1;
    localparam logic [CNT_W-1:0] HOLD_V = CNT_W'(HOLD_AT);
    localparam logic [CNT_W-1:0] MIN_V  = CNT_W'(MIN_LEN);

    logic                          hunt;
    logic [CNT_W-1:0]              cnt;
    logic [15:0]                   crc;
    logic [BYTE_W-1:0]             pend;
    logic [FCS_LEN-1:0][BYTE_W-1:0] win;
    logic                          pend_ok;

    assign pend_ok = (cnt >= HOLD_V);

    always_comb begin
        emit = 1'b0;
        beat = '0;
        if (take && !hunt) begin
            case (kind)
                CK_DATA: begin
                    if (pend_ok) begin
                        emit      = 1'b1;
                        beat.data = pend;
                    end
                end
                CK_FLAG: begin
                    if (cnt != '0) begin
                        emit                = 1'b1;
                        beat.last           = 1'b1;
                        beat.data           = pend_ok ? pend : '0;
                        beat.stat.too_short = (cnt < MIN_V);
                        beat.stat.crc_bad   = (cnt >= MIN_V) && (crc != CRC_GOOD);
                    end
                end
                CK_ABORT: begin
                    emit              = 1'b1;
                    beat.last         = 1'b1;
                    beat.data         = pend_ok ? pend : '0;
                    beat.stat.aborted = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hunt <= 1'b1;
            cnt  <= '0;
            crc  <= CRC_INIT;
            pend <= '0;
            win  <= '0;
        end else if (take) begin
            case (kind)
                CK_DATA: begin
                    if (!hunt) begin
                        if (cnt != MIN_V) cnt <= cnt + 1'b1;
                        crc    <= crc16_byte(crc, byte_i);
                        pend   <= win[FCS_LEN-1];
                        win[0] <= byte_i;
                        for (int i = 1; i < FCS_LEN; i++) begin
                            win[i] <= win[i-1];
                        end
                    end
                end
                CK_FLAG, CK_ABORT: begin
                    hunt <= 1'b0;
                    cnt  <= '0;
                    crc  <= CRC_INIT;
                end
                default: ;
            endcase
        end
    end

    // R2
    restart_chk: assert property (@(posedge clk) disable iff (rst)
        emit && beat.last |=> (cnt == '0) && (crc == CRC_INIT) && !hunt);

    // R1
    hunt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        hunt |-> !emit);

endmodule

// File: rtl/hdlcd_outreg.sv
module hdlcd_outreg
    import hdlcd_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   emit,
    input  beat_t  beat_i,
    input  logic   out_ready,
    output logic   in_ready,
    output logic   out_valid,
    output beat_t  beat_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            beat_o    <= '0;
        end else if (emit) begin
            out_valid <= 1'b1;
            beat_o    <= beat_i;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    assign in_ready = !out_valid || out_ready;

    // R10
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(beat_o));

    // R7
    status_on_last_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && !beat_o.last |-> (beat_o.stat == '0));

    // R9
    status_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $onehot0(beat_o.stat));

endmodule

// File: rtl/hdlc_async_deframer.sv
module hdlc_async_deframer
    import hdlcd_pkg::*;
#(
    parameter int MIN_LEN = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [BYTE_W-1:0]     cfg_flag,
    input  logic [BYTE_W-1:0]     cfg_esc,
    input  logic [CTRL_SPAN-1:0]  cfg_ctrl_map,
    input  logic                  in_valid,
    input  logic [BYTE_W-1:0]     in_data,
    output logic                  in_ready,
    output logic                  out_valid,
    input  logic                  out_ready,
    output logic [BYTE_W-1:0]     out_data,
    output logic                  out_last,
    output logic [2:0]            out_status
);

    logic              take;
    chr_kind_t         kind;
    logic [BYTE_W-1:0] clean;
    logic              emit;
    beat_t             beat_new;
    beat_t             beat_out;

    assign take = in_valid && in_ready;

    hdlcd_classify u_class (
        .clk      (clk),
        .rst      (rst),
        .cfg_flag (cfg_flag),
        .cfg_esc  (cfg_esc),
        .cfg_map  (cfg_ctrl_map),
        .take     (take),
        .ch       (in_data),
        .kind     (kind),
        .byte_o   (clean)
    );

    hdlcd_frame #(.MIN_LEN(MIN_LEN)) u_frame (
        .clk    (clk),
        .rst    (rst),
        .take   (take),
        .kind   (kind),
        .byte_i (clean),
        .emit   (emit),
        .beat   (beat_new)
    );

    hdlcd_outreg u_out (
        .clk       (clk),
        .rst       (rst),
        .emit      (emit),
        .beat_i    (beat_new),
        .out_ready (out_ready),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .beat_o    (beat_out)
    );

    assign out_data   = beat_out.data;
    assign out_last   = beat_out.last;
    assign out_status = beat_out.stat;

    // R10
    rise_needs_take_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> $past(in_valid && in_ready));

    // R11
    ready_when_free_chk: assert property (@(posedge clk) disable iff (rst)
        out_ready |-> in_ready);

endmodule

// File: tb/hdlc_async_deframer_tb.sv
module hdlc_async_deframer_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  cfg_flag, cfg_esc;
    logic [31:0] cfg_ctrl_map;
    logic        in_valid;
    logic [7:0]  in_data;
    logic        in_ready;
    logic        out_valid;
    logic        out_ready;
    logic [7:0]  out_data;
    logic        out_last;
    logic [2:0]  out_status;

    always #5 clk = ~clk;

    hdlc_async_deframer dut_i (
        .clk(clk), .rst(rst), .cfg_flag(cfg_flag), .cfg_esc(cfg_esc),
        .cfg_ctrl_map(cfg_ctrl_map), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_last(out_last), .out_status(out_status)
    );

    int    errors = 0;
    int    checks = 0;
    string cur_req = "R11";
    bit    hold = 1'b0;
    int    ready_pct = 100;
    bit    finished = 1'b0;
    logic [11:0] exp_q[$];
    logic [7:0]  fb[0:31];

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        out_ready = hold ? 1'b0 : ($urandom_range(99) < ready_pct);
    end

    always @(negedge clk) begin
        #2;
        if (!rst && out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                check(cur_req, {20'd0, out_data, out_last, out_status}, 32'hFFFF_FFFF);
            end else begin
                logic [11:0] e;
                e = exp_q.pop_front();
                check(cur_req, {20'd0, out_data, out_last, out_status}, {20'd0, e});
            end
        end
    end

    function automatic logic [15:0] ref_crc(input int m);
        logic [15:0] c = 16'hFFFF;
        for (int i = 0; i < m; i++) begin
            c = c ^ {8'h00, fb[i]};
            for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 16'h8408) : (c >> 1);
        end
        return c;
    endfunction

    function automatic bit need_esc(input logic [7:0] b);
        return (b == cfg_flag) || (b == cfg_esc) || (b < 8'd32 && cfg_ctrl_map[b[4:0]]);
    endfunction

    // Expected beats per R7, R8, R9, R6
    task automatic expect_frame(input int m, input bit abort);
        logic [7:0] d;
        logic [2:0] st;
        if (!abort && m == 0) return;
        for (int i = 0; i <= m - 4; i++) exp_q.push_back({fb[i], 1'b0, 3'b000});
        d = (m >= 3) ? fb[m-3] : 8'h00;
        if (abort) st = 3'b010;
        else if (m < 4) st = 3'b100;
        else st = (ref_crc(m) != 16'hF0B8) ? 3'b001 : 3'b000;
        exp_q.push_back({d, 1'b1, st});
    endtask

    task automatic send_char(input logic [7:0] c);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = c;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic send_noise();
        for (int t = 0; t < 40; t++) begin
            logic [7:0] v;
            v = 8'($urandom_range(31));
            if (cfg_ctrl_map[v[4:0]] && v != cfg_flag && v != cfg_esc) begin
                send_char(v);
                return;
            end
        end
    endtask

    task automatic send_body(input int m, input int noise_pct);
        for (int i = 0; i < m; i++) begin
            logic [7:0] b;
            b = fb[i];
            if ($urandom_range(99) < noise_pct) send_noise();
            if (need_esc(b) || ($urandom_range(7) == 0 && (b ^ 8'h20) != cfg_flag)) begin
                send_char(cfg_esc);
                send_char(b ^ 8'h20);
            end else begin
                send_char(b);
            end
        end
    endtask

    task automatic build_frame(input int n, input bit bad, output int m);
        logic [15:0] f;
        for (int i = 0; i < n; i++) fb[i] = 8'($urandom_range(255));
        f = ~ref_crc(n);
        fb[n]   = f[7:0];
        fb[n+1] = f[15:8];
        if (bad) fb[n] = fb[n] ^ 8'h01;
        m = n + 2;
    endtask

    task automatic good_frame(input int n, input bit bad, input int noise_pct);
        int m;
        build_frame(n, bad, m);
        expect_frame(m, 1'b0);
        send_body(m, noise_pct);
        send_char(cfg_flag);
    endtask

    task automatic drain();
        for (int t = 0; t < 400; t++) begin
            @(negedge clk);
            if (exp_q.size() == 0 && !out_valid) break;
        end
        #3;
        check({cur_req, " drained"}, exp_q.size(), 0);
    endtask

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; in_valid = 1'b0; in_data = 8'h00;
        cfg_flag = 8'h7E; cfg_esc = 8'h7D; cfg_ctrl_map = 32'h000A_0008;
        repeat (5) @(posedge clk);
        #1;
        check("R11 out_valid", out_valid, 0);
        check("R11 in_ready", in_ready, 1);
        rst = 1'b0;
        @(negedge clk); #3;
        check("R11 out_valid after", out_valid, 0);

        // R1: characters before first flag are ignored
        cur_req = "R1";
        send_char(8'h11); send_char(8'h22); send_char(8'h55); send_char(8'h41);
        send_char(8'h42); send_char(8'h43); send_char(8'h44);
        send_char(cfg_flag);
        good_frame(3, 1'b0, 0);
        drain();

        // R2: shared flag between frames
        cur_req = "R2";
        good_frame(5, 1'b0, 0);
        good_frame(2, 1'b0, 0);
        drain();

        // R9: empty and short frames
        cur_req = "R9";
        send_char(cfg_flag); send_char(cfg_flag);
        fb[0] = 8'hA5; expect_frame(1, 1'b0); send_body(1, 0); send_char(cfg_flag);
        fb[0] = 8'h31; fb[1] = 8'h32; fb[2] = 8'h33;
        expect_frame(3, 1'b0); send_body(3, 0); send_char(cfg_flag);
        drain();

        // R6: bad CRC
        cur_req = "R6";
        good_frame(6, 1'b1, 0);
        good_frame(4, 1'b0, 0);
        drain();

        // R8: abort and resync on the same flag
        cur_req = "R8";
        for (int i = 0; i < 5; i++) fb[i] = 8'h60 + 8'(i);
        expect_frame(5, 1'b1); send_body(5, 0);
        send_char(cfg_esc); send_char(cfg_flag);
        good_frame(3, 1'b0, 0);
        expect_frame(0, 1'b1);
        send_char(cfg_esc); send_char(cfg_flag);
        drain();

        // R3: data needing transparency
        cur_req = "R3";
        begin
            int m;
            fb[0] = 8'h7E; fb[1] = 8'h7D; fb[2] = 8'h03; fb[3] = 8'h11;
            fb[4] = 8'h5E; fb[5] = 8'h13;
            fb[6] = ~ref_crc(6) & 8'hFF;
            begin
                logic [15:0] f; f = ~ref_crc(6); fb[6] = f[7:0]; fb[7] = f[15:8];
            end
            m = 8;
            expect_frame(m, 1'b0); send_body(m, 0); send_char(cfg_flag);
        end
        drain();

        // R4: mapped control characters dropped
        cur_req = "R4";
        good_frame(7, 1'b0, 100);
        send_char(8'h03); send_char(8'h13);
        send_char(cfg_flag);
        drain();

        // R10: stall holds beat and blocks input
        cur_req = "R10";
        hold = 1'b1;
        fork
            good_frame(8, 1'b0, 0);
            begin
                repeat (60) @(negedge clk);
                #3;
                check("R10 out_valid held", out_valid, 1);
                check("R10 in_ready low", in_ready, 0);
                check("R10 data held", out_data, exp_q[0][11:4]);
                hold = 1'b0;
            end
        join
        drain();

        // R5: programmable flag, escape and map
        cur_req = "R5";
        cfg_flag = 8'hC0; cfg_esc = 8'hDB; cfg_ctrl_map = 32'h0000_0A00;
        send_char(cfg_flag);
        begin
            int m;
            fb[0] = 8'h7E; fb[1] = 8'h7D; fb[2] = 8'hC0; fb[3] = 8'h09;
            begin
                logic [15:0] f; f = ~ref_crc(4); fb[4] = f[7:0]; fb[5] = f[15:8];
            end
            m = 6;
            expect_frame(m, 1'b0); send_body(m, 0); send_char(cfg_flag);
        end
        drain();

        // R7: random mix
        cur_req = "R7";
        ready_pct = 70;
        for (int f = 0; f < 160; f++) begin
            int kind;
            if (f == 80) begin
                drain();
                cfg_flag = 8'h7E; cfg_esc = 8'h7D; cfg_ctrl_map = 32'($urandom());
                send_char(cfg_flag);
            end
            kind = $urandom_range(9);
            if (kind < 7) good_frame($urandom_range(12, 2), 1'b0, 10);
            else if (kind == 7) good_frame($urandom_range(8, 2), 1'b1, 10);
            else if (kind == 8) begin
                int m;
                m = $urandom_range(3, 1);
                for (int i = 0; i < m; i++) fb[i] = 8'($urandom_range(255));
                expect_frame(m, 1'b0); send_body(m, 10); send_char(cfg_flag);
            end else begin
                int m;
                m = $urandom_range(6);
                for (int i = 0; i < m; i++) fb[i] = 8'($urandom_range(255));
                expect_frame(m, 1'b1); send_body(m, 10);
                send_char(cfg_esc); send_char(cfg_flag);
            end
            if ($urandom_range(3) == 0) send_char(cfg_flag);
        end
        drain();

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL R10: watchdog expired act=running exp=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule